// File: doc/BRIEF.md
# Farm Destination Credit Manager

This block decides which processing node in the event-building farm receives the next multi-event packet. Idle nodes announce themselves with a node identifier and a capacity expressed in credits. Each announcement waits in a small first-in first-out pool. One pool entry at a time is the current destination, and its identifier is broadcast to the readout modules.

Every level-1 accept that arrives while a destination is current is tagged with that destination's identifier, and the event is charged one credit. When the accept that spends the last credit arrives, the packet closes, a close strobe pulses, and the next pooled entry becomes the destination. The close is tied to the accept stream. If the closing accept reports that its data overlaps the following event, the close waits until a later accept arrives without overlap. A throttle output asks the trigger to hold off when no further destination is available.

Top module: `farm_credit_dispatcher`

## Requirements
- R1: After reset, destValid, tagValid, closeStrobe and availDropped are 0, and throttle is 1.
- R2: An availability request with nonzero credits is stored in the pool. When no destination is current and the pool is not empty, the oldest entry becomes current at the next clock edge, and destValid and destNode show it.
- R3: An availability request whose credit field is 0 is discarded. It does not enter the pool and does not raise availDropped.
- R4: A request with nonzero credits that arrives while the pool already holds DEPTH entries, counted before any removal in that cycle, is discarded. availDropped is then 1 for exactly the following cycle.
- R5: An accept that arrives while a destination is current sets tagValid for the following cycle. In that cycle tagEvent carries the accept's event number and tagNode carries the destination that was current when the accept arrived.
- R6: An accept that arrives while no destination is current is ignored, and tagValid stays 0.
- R7: Each tagged accept spends one credit. If the accept that spends the last remaining credit has l1Overlap = 0, closeStrobe is 1 for exactly the following cycle. In that same cycle the next pooled entry becomes current, or destValid drops to 0 if the pool is empty.
- R8: If the accept that spends the last credit has l1Overlap = 1, the close is held back. Later accepts are still tagged with the same node. The first later accept with l1Overlap = 0 performs the close as in R7.
- R9: throttle is 1 exactly when the pool is empty and either no destination is current or a close is being held back.
- R10: Destinations become current in the order their requests were accepted into the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| availValid | input | 1 | Availability request strobe |
| availNode | input | NODE_W | Identifier of the announcing node |
| availCredits | input | CRED_W | Capacity of the announcing node, in credits |
| l1Accept | input | 1 | Level-1 accept strobe |
| l1EventNum | input | EVT_W | Event number of the accept |
| l1Overlap | input | 1 | The accepted event's data overlaps the next event |
| destValid | output | 1 | A destination is current |
| destNode | output | NODE_W | Current destination broadcast to the readout modules |
| tagValid | output | 1 | An event has been assigned a destination |
| tagEvent | output | EVT_W | Event number of the assigned event |
| tagNode | output | NODE_W | Node the event was assigned to |
| closeStrobe | output | 1 | The packet was closed in the previous cycle |
| availDropped | output | 1 | A request was discarded because the pool was full |
| throttle | output | 1 | No further destination is available |

## Verification
Two functions can fall in the same clock cycle: a closing accept that removes the pool head, and an availability request that tries to add to the pool. This also happens when the pool is full, and when the pool is empty so that the new entry is not yet visible. The bench drives small credit values and dense request and accept streams to provoke these coincidences many times. A cycle-level model of the pool, written from the requirements, predicts each outcome. The model counts pool occupancy before removal, which decides whether a request is dropped, and it checks that a request arriving during an empty-pool close becomes current only one cycle later.

// File: rtl/fdcm_pkg.sv
package fdcm_pkg;
  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic push;   // store incoming availability entry
    logic pop;    // remove pool head
    logic load;   // head becomes current destination
    logic clear;  // current destination retired with nothing to replace it
    logic decr;   // spend one credit
    logic tag;    // assign accepted event to current destination
    logic close;  // packet closed this cycle
    logic drop;   // request discarded for lack of room
  } ctlStrobes_t;
endpackage

// File: rtl/fdcm_datapath.sv
module fdcm_datapath
  import fdcm_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int CRED_W = 6,
  parameter int EVT_W  = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strb,
  input  logic [NODE_W-1:0] availNode,
  input  logic [CRED_W-1:0] availCredits,
  input  logic [EVT_W-1:0]  l1EventNum,
  output logic [CNT_W-1:0]  poolCount,
  output logic              curValid,
  output logic [NODE_W-1:0] curNode,
  output logic [CRED_W-1:0] curCredits,
  output logic              tagValid,
  output logic [EVT_W-1:0]  tagEvent,
  output logic [NODE_W-1:0] tagNode,
  output logic              closeStrobe,
  output logic              availDropped
);
  logic [NODE_W-1:0] nodeMem [DEPTH];
  logic [CRED_W-1:0] credMem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) begin
      nodeMem[wrPtr] <= availNode;
      credMem[wrPtr] <= availCredits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      poolCount <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   poolCount <= poolCount + 1'b1;
        2'b01:   poolCount <= poolCount - 1'b1;
        default: poolCount <= poolCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curValid   <= 1'b0;
      curNode    <= '0;
      curCredits <= '0;
    end else if (strb.load) begin
      curValid   <= 1'b1;
      curNode    <= nodeMem[rdPtr];
      curCredits <= credMem[rdPtr];
    end else if (strb.clear) begin
      curValid   <= 1'b0;
      curCredits <= '0;
    end else if (strb.decr && curCredits != '0) begin
      curCredits <= curCredits - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tagValid     <= 1'b0;
      tagEvent     <= '0;
      tagNode      <= '0;
      closeStrobe  <= 1'b0;
      availDropped <= 1'b0;
    end else begin
      tagValid     <= strb.tag;
      closeStrobe  <= strb.close;
      availDropped <= strb.drop;
      if (strb.tag) begin
        tagEvent <= l1EventNum;
        tagNode  <= curNode;
      end
    end
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poolCount <= CNT_W'(DEPTH));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> poolCount != '0);

  // R4
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poolCount == CNT_W'(DEPTH) && !strb.pop) |=> poolCount == CNT_W'(DEPTH) || $past(strb.pop) || !$past(strb.push));
endmodule

// File: rtl/fdcm_control.sv
module fdcm_control
  import fdcm_pkg::*;
#(
  parameter int CRED_W = 6,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              availValid,
  input  logic [CRED_W-1:0] availCredits,
  input  logic              l1Accept,
  input  logic              l1Overlap,
  input  logic [CNT_W-1:0]  poolCount,
  input  logic              curValid,
  input  logic [CRED_W-1:0] curCredits,
  input  logic              tagValid,
  input  logic              closeStrobe,
  input  logic              availDropped,
  output ctlStrobes_t       strb,
  output logic              throttle
);
  logic pendClose;
  logic poolEmpty, poolFull, lastCredit, validReq;

  always_comb begin
    poolEmpty  = (poolCount == '0);
    poolFull   = (poolCount == CNT_W'(DEPTH));
    lastCredit = (curCredits <= CRED_W'(1));
    validReq   = availValid && (availCredits != '0);

    strb       = '0;
    strb.tag   = l1Accept && curValid;
    strb.decr  = strb.tag;
    strb.close = strb.tag && lastCredit && !l1Overlap;
    strb.pop   = !poolEmpty && (strb.close || !curValid);
    strb.load  = strb.pop;
    strb.clear = strb.close && poolEmpty;
    strb.push  = validReq && !poolFull;
    strb.drop  = validReq && poolFull;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      pendClose <= 1'b0;
    else if (!curValid || strb.close) pendClose <= 1'b0;
    else if (strb.tag && lastCredit)  pendClose <= 1'b1;
  end

  assign throttle = poolEmpty && (!curValid || pendClose);

  // R5
  tag_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tagValid |-> $past(l1Accept));

  // R7
  close_needs_clean_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    closeStrobe |-> $past(l1Accept && !l1Overlap));

  // R4
  drop_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    availDropped |-> $past(availValid) && $past(availCredits) != '0);

  // R8
  hold_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendClose && !l1Accept) |=> pendClose);
endmodule

// File: rtl/farm_credit_dispatcher.sv
module farm_credit_dispatcher
  import fdcm_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int CRED_W = 6,
  parameter int EVT_W  = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              availValid,
  input  logic [NODE_W-1:0] availNode,
  input  logic [CRED_W-1:0] availCredits,
  input  logic              l1Accept,
  input  logic [EVT_W-1:0]  l1EventNum,
  input  logic              l1Overlap,
  output logic              destValid,
  output logic [NODE_W-1:0] destNode,
  output logic              tagValid,
  output logic [EVT_W-1:0]  tagEvent,
  output logic [NODE_W-1:0] tagNode,
  output logic              closeStrobe,
  output logic              availDropped,
  output logic              throttle
);
  ctlStrobes_t       strb;
  logic [CNT_W-1:0]  poolCount;
  logic [CRED_W-1:0] curCredits;

  fdcm_control #(.CRED_W(CRED_W), .DEPTH(DEPTH)) ctrl (
    .clk(clk), .rst_n(rst_n),
    .availValid(availValid), .availCredits(availCredits),
    .l1Accept(l1Accept), .l1Overlap(l1Overlap),
    .poolCount(poolCount), .curValid(destValid), .curCredits(curCredits),
    .tagValid(tagValid), .closeStrobe(closeStrobe), .availDropped(availDropped),
    .strb(strb), .throttle(throttle)
  );

  fdcm_datapath #(.NODE_W(NODE_W), .CRED_W(CRED_W), .EVT_W(EVT_W), .DEPTH(DEPTH)) dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .availNode(availNode), .availCredits(availCredits), .l1EventNum(l1EventNum),
    .poolCount(poolCount), .curValid(destValid), .curNode(destNode),
    .curCredits(curCredits),
    .tagValid(tagValid), .tagEvent(tagEvent), .tagNode(tagNode),
    .closeStrobe(closeStrobe), .availDropped(availDropped)
  );
endmodule

// File: tb/farm_credit_dispatcher_test.sv
`timescale 1ns/1ps
module farm_credit_dispatcher_test;
  localparam int NODE_W = 8;
  localparam int CRED_W = 6;
  localparam int EVT_W  = 16;
  localparam int DEPTH  = 4;
  localparam int MAX_CYCLES = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              availValid = 1'b0;
  logic [NODE_W-1:0] availNode = '0;
  logic [CRED_W-1:0] availCredits = '0;
  logic              l1Accept = 1'b0;
  logic [EVT_W-1:0]  l1EventNum = '0;
  logic              l1Overlap = 1'b0;
  logic              destValid, tagValid, closeStrobe, availDropped, throttle;
  logic [NODE_W-1:0] destNode, tagNode;
  logic [EVT_W-1:0]  tagEvent;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  farm_credit_dispatcher #(.NODE_W(NODE_W), .CRED_W(CRED_W), .EVT_W(EVT_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .availValid(availValid), .availNode(availNode), .availCredits(availCredits),
    .l1Accept(l1Accept), .l1EventNum(l1EventNum), .l1Overlap(l1Overlap),
    .destValid(destValid), .destNode(destNode),
    .tagValid(tagValid), .tagEvent(tagEvent), .tagNode(tagNode),
    .closeStrobe(closeStrobe), .availDropped(availDropped), .throttle(throttle)
  );

  // Reference model state
  int mNode[$];
  int mCred[$];
  bit mValid = 0;
  int mCur = 0;
  int mLeft = 0;
  bit mPend = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit av, input int node, input int cred,
                      input bit acc, input int evt, input bit ovl);
    bit req, full, push, tag, closeNow, popNow, wasPend, expThr;
    int tagN;
    @(negedge clk);
    availValid = av; availNode = NODE_W'(node); availCredits = CRED_W'(cred);
    l1Accept = acc; l1EventNum = EVT_W'(evt); l1Overlap = ovl;

    req      = av && cred != 0;
    full     = mNode.size() == DEPTH;
    push     = req && !full;
    tag      = acc && mValid;
    tagN     = mCur;
    closeNow = tag && mLeft <= 1 && !ovl;
    popNow   = mNode.size() > 0 && (closeNow || !mValid);
    wasPend  = mPend;

    if (!mValid || closeNow) mPend = 0;
    else if (tag && mLeft <= 1) mPend = 1;
    if (tag && mLeft > 0) mLeft--;
    if (popNow) begin
      mValid = 1; mCur = mNode.pop_front(); mLeft = mCred.pop_front();
    end else if (closeNow) mValid = 0;
    if (push) begin mNode.push_back(node); mCred.push_back(cred); end
    expThr = (mNode.size() == 0) && (!mValid || mPend);

    @(posedge clk);
    #2;
    check(tagValid == tag, tag ? "R5" : "R6", "tagValid", tagValid, tag);
    if (tag) begin
      check(tagNode == NODE_W'(tagN), "R5", "tagNode", tagNode, tagN);
      check(tagEvent == EVT_W'(evt), "R5", "tagEvent", tagEvent, evt);
    end
    check(closeStrobe == closeNow, wasPend ? "R8" : "R7", "closeStrobe", closeStrobe, closeNow);
    if (av && cred == 0)
      check(availDropped == 0, "R3", "availDropped", availDropped, 0);
    else
      check(availDropped == (req && full), "R4", "availDropped", availDropped, req && full);
    check(destValid == mValid, "R2", "destValid", destValid, mValid);
    if (mValid)
      check(destNode == NODE_W'(mCur), "R10", "destNode", destNode, mCur);
    check(throttle == expThr, "R9", "throttle", throttle, expThr);
  endtask

  initial begin
    #(20.0 * MAX_CYCLES);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(destValid == 0, "R1", "destValid", destValid, 0);
    check(tagValid == 0, "R1", "tagValid", tagValid, 0);
    check(closeStrobe == 0, "R1", "closeStrobe", closeStrobe, 0);
    check(availDropped == 0, "R1", "availDropped", availDropped, 0);
    check(throttle == 1, "R1", "throttle", throttle, 1);

    // Directed: accept with nothing pooled (R6), zero-credit request (R3)
    step(0, 0, 0, 1, 7, 0);
    step(1, 9, 0, 0, 0, 0);
    // Fill beyond depth (R4), then consume with a held close (R8)
    step(1, 1, 2, 0, 0, 0);
    step(1, 2, 1, 0, 0, 0);
    step(1, 3, 1, 0, 0, 0);
    step(1, 4, 3, 0, 0, 0);
    step(1, 5, 1, 0, 0, 0);
    step(1, 6, 1, 0, 0, 0);
    step(0, 0, 0, 1, 100, 0);
    step(0, 0, 0, 1, 101, 1);
    step(0, 0, 0, 1, 102, 1);
    step(0, 0, 0, 0, 0, 0);
    step(1, 8, 2, 1, 103, 0);
    for (int k = 0; k < 12; k++) step(0, 0, 0, 1, 200 + k, 0);

    // Sweeps over request/accept densities and credit sizes
    for (int phase = 0; phase < 4; phase++) begin
      for (int i = 0; i < 3000; i++) begin
        int r = $urandom;
        bit av  = (r % 4) < (phase + 1);
        bit acc = ((r >> 4) % 4) < (3 - phase % 2);
        bit ovl = ((r >> 8) % 4) == 0;
        int cr  = (r >> 12) % (phase + 3);
        step(av, (r >> 16) % 256, cr, acc, i, ovl);
      end
    end
    // Drain
    for (int k = 0; k < 40; k++) step(0, 0, 0, 1, k, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule